// File: doc/BRIEF.md
# Random Word Service Controller

This block sits between a host bus and a stream of raw random words. The host drives it with fixed 32-bit command words written to a single command location. The block moves through a short bring-up: a reset acknowledge, a release, an enable, and a zeroize step that launches a startup health test. When the host accepts a passing verdict, the block enters service. Progress is reported as a one-byte status code, which the host polls at its own location.

In service the block captures one raw word from the `src_valid`/`src_data` stream and holds it. It advertises that word with the fresh-word status until the host retires it. Retiring takes two writes: a read-acknowledge, then an enable. Only the enable arms capture of the next word. The startup health test is a stand-in. It counts a fixed number of incoming samples and rejects the source when identical consecutive samples repeat too often. A test input can also force a failing verdict. Commands that are out of order or not recognised change nothing.

Top module: `rng_host_ctrl`

## Requirements
- R1: Bus map: a write at offset 0x0 is a command, a read at offset 0x4 returns the status code in bits 7:0 with upper bits zero, and a read at offset 0x0 returns the data word. Read data is registered and appears one clock after the read strobe. It is zero in any cycle after no read strobe, and zero for any other offset.
- R2: Command 0x00000001 is accepted in every state. From the following clock, status reads 0xAC.
- R3: Bring-up advances only in this order: 0x00000002 when status is 0xAC, then 0x80000000, then 0x80000004. Status reads 0x00 in the two intermediate states and after power-on reset.
- R4: Command 0x80000004 starts a health test over NSAMP valid samples, with status 0x00 while it runs. Status becomes 0x57 (pass) or 0xFA (fail) on the clock that accepts the last sample.
- R5: The test fails if more than REP_LIMIT consecutive samples are identical. It also fails if `test_force_fail` is high in any cycle of the test.
- R6: After a pass, nothing is captured until command 0x80000008. That command enters service with status 0x00.
- R7: In service, the first valid source word is captured. Status then reads 0xED, and data reads return that word. Later source words do not replace it.
- R8: Command 0x8000000F while status is 0xED sets status to 0x00. No word is captured until command 0x80000000. After that command, the next valid word is captured.
- R9: A data read returns zero unless status is 0xED. Reset and zeroize clear the held word.
- R10: These leave state and status unchanged: unrecognised command words, commands out of sequence (0x80000008 after a failed test, for example), and writes to any offset other than 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Host write strobe |
| bus_re | input | 1 | Host read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data (command word) |
| bus_rdata | output | 32 | Registered read data |
| src_valid | input | 1 | Raw random word valid |
| src_data | input | DATA_W | Raw random word |
| test_force_fail | input | 1 | Forces the startup test to fail |

## Verification
The bench goes after the corners of the read/retire handshake. It re-polls after the read-acknowledge while the source keeps streaming. A design that re-armed on the acknowledge alone would show 0xED again too early. The bench also checks that a held word survives later source words; a design that kept loading would change data between reads. It feeds a constant source and a forced-fail pulse to the health test, so a test that missed runs or missed the force input would post 0x57 where 0xFA is due. Stray, misplaced and out-of-order commands are all sent, so a decoder that is too loose would show a changed status.

// File: rtl/rng_host_pkg.sv
package rng_host_pkg;
  localparam logic [31:0] CMD_RESET   = 32'h0000_0001;
  localparam logic [31:0] CMD_RELEASE = 32'h0000_0002;
  localparam logic [31:0] CMD_ENABLE  = 32'h8000_0000;
  localparam logic [31:0] CMD_ZEROIZE = 32'h8000_0004;
  localparam logic [31:0] CMD_ACKZ    = 32'h8000_0008;
  localparam logic [31:0] CMD_RDACK   = 32'h8000_000F;

  localparam logic [7:0] STS_RSTACK = 8'hAC;
  localparam logic [7:0] STS_PASS   = 8'h57;
  localparam logic [7:0] STS_FAIL   = 8'hFA;
  localparam logic [7:0] STS_FRESH  = 8'hED;

  typedef enum logic [3:0] {
    PH_IDLE, PH_RSTACK, PH_RELEASED, PH_ENABLED, PH_TEST,
    PH_PASS, PH_FAIL, PH_ARMED, PH_FRESH, PH_DRAINED
  } phase_t;

  function automatic logic [7:0] status_of(input phase_t p);
    case (p)
      PH_RSTACK: return STS_RSTACK;
      PH_PASS:   return STS_PASS;
      PH_FAIL:   return STS_FAIL;
      PH_FRESH:  return STS_FRESH;
      default:   return 8'h00;
    endcase
  endfunction

  // Returns p unchanged when the command is not legal in phase p.
  function automatic phase_t next_on_cmd(input phase_t p, input logic [31:0] c);
    if (c == CMD_RESET) return PH_RSTACK;
    case (p)
      PH_RSTACK:   return (c == CMD_RELEASE) ? PH_RELEASED : p;
      PH_RELEASED: return (c == CMD_ENABLE)  ? PH_ENABLED  : p;
      PH_ENABLED:  return (c == CMD_ZEROIZE) ? PH_TEST     : p;
      PH_PASS:     return (c == CMD_ACKZ)    ? PH_ARMED    : p;
      PH_FRESH:    return (c == CMD_RDACK)   ? PH_DRAINED  : p;
      PH_DRAINED:  return (c == CMD_ENABLE)  ? PH_ARMED    : p;
      default:     return p;
    endcase
  endfunction
endpackage

// File: rtl/rng_rep_check.sv
module rng_rep_check #(
  parameter int DATA_W    = 32,
  parameter int NSAMP     = 64,
  parameter int REP_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              active,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              force_fail,
  output logic              done,
  output logic              fail
);
  localparam int CNT_W = $clog2(NSAMP + 1);
  localparam int RUN_W = $clog2(REP_LIMIT + 2);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] prev;
  logic              have_prev;
  logic [RUN_W-1:0]  run;
  logic              fail_flag;

  function automatic logic [RUN_W-1:0] bump_run(input logic [RUN_W-1:0] r, input logic same);
    if (!same) return RUN_W'(1);
    if (r > RUN_W'(REP_LIMIT)) return r;
    return r + RUN_W'(1);
  endfunction

  logic             take, same, run_bad;
  logic [RUN_W-1:0] run_next;

  assign take     = active && smp_valid;
  assign same     = have_prev && (smp_data == prev);
  assign run_next = bump_run(run, same);
  assign run_bad  = take && (run_next > RUN_W'(REP_LIMIT));
  assign done     = take && (cnt == CNT_W'(NSAMP - 1));
  assign fail     = fail_flag || run_bad || (active && force_fail);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt       <= '0;
      prev      <= '0;
      have_prev <= 1'b0;
      run       <= '0;
      fail_flag <= 1'b0;
    end else begin
      if (active && force_fail) fail_flag <= 1'b1;
      if (take) begin
        cnt       <= cnt + CNT_W'(1);
        prev      <= smp_data;
        have_prev <= 1'b1;
        run       <= run_next;
        if (run_bad) fail_flag <= 1'b1;
      end
    end
  end

  a_r4_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0 && !have_prev));
  a_r5_verdict_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (run_bad && !clear) |=> fail);
endmodule

// File: rtl/rng_word_hold.sv
module rng_word_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) dout <= '0;
    else if (load)       dout <= din;
  end

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (dout == '0));
endmodule

// File: rtl/rng_host_ctrl.sv
module rng_host_ctrl
  import rng_host_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int NSAMP     = 64,
  parameter int REP_LIMIT = 3,
  parameter int CMD_OFFS  = 0,
  parameter int STAT_OFFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  input  logic              test_force_fail
);
  phase_t phase, phase_d, cmd_target;
  logic   cmd_valid, cmd_accept, clear_all, load_word, is_fresh;
  logic   test_done, test_fail;
  logic [DATA_W-1:0] held;

  assign cmd_valid  = bus_we && (bus_addr == ADDR_W'(CMD_OFFS));
  assign cmd_target = next_on_cmd(phase, bus_wdata);
  assign cmd_accept = cmd_valid && (cmd_target != phase);
  assign clear_all  = cmd_accept && (cmd_target == PH_RSTACK || cmd_target == PH_TEST);
  assign load_word  = (phase == PH_ARMED) && src_valid && !cmd_accept;
  assign is_fresh   = (phase == PH_FRESH);

  rng_rep_check #(.DATA_W(DATA_W), .NSAMP(NSAMP), .REP_LIMIT(REP_LIMIT)) u_check (
    .clk(clk), .rst_n(rst_n), .clear(clear_all), .active(phase == PH_TEST),
    .smp_valid(src_valid), .smp_data(src_data), .force_fail(test_force_fail),
    .done(test_done), .fail(test_fail)
  );

  rng_word_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clear(clear_all), .load(load_word),
    .din(src_data), .dout(held)
  );

  always_comb begin
    phase_d = phase;
    if (cmd_accept)                           phase_d = cmd_target;
    else if (phase == PH_TEST && test_done)   phase_d = test_fail ? PH_FAIL : PH_PASS;
    else if (load_word)                       phase_d = PH_FRESH;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !bus_re) bus_rdata <= '0;
    else if (bus_addr == ADDR_W'(STAT_OFFS)) bus_rdata <= {24'h0, status_of(phase)};
    else if (bus_addr == ADDR_W'(CMD_OFFS) && is_fresh) bus_rdata <= 32'(held);
    else bus_rdata <= '0;
  end

  a_r7_fresh_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_fresh) |-> $past(load_word));
  a_r8_drained_not_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DRAINED) |=> (phase != PH_FRESH));
  a_r1_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_re) |-> (bus_rdata == '0));
  a_r9_stale_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_re && bus_addr == ADDR_W'(CMD_OFFS) && !is_fresh) |-> (bus_rdata == '0));
  a_r4_test_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TEST && test_done && !cmd_accept) |=> (phase == PH_PASS || phase == PH_FAIL));
  a_r2_reset_cmd_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && bus_wdata == CMD_RESET) |=> (phase == PH_RSTACK));
endmodule

// File: tb/rng_host_ctrl_tb.sv
module rng_host_ctrl_tb_top;
  localparam int NSAMP = 64;
  localparam int REPL  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic src_valid = 1'b0, test_force_fail = 1'b0;
  logic [31:0] src_data = '0;

  int checks = 0, fails = 0;
  int src_mode = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #5 clk = ~clk;

  rng_host_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_valid(src_valid),
    .src_data(src_data), .test_force_fail(test_force_fail)
  );

  // ---------------- behavioural reference model ----------------
  // states: 0 idle 1 rstack 2 released 3 enabled 4 test 5 pass 6 fail 7 armed 8 fresh 9 drained
  int          m_state = 0;
  logic [31:0] m_word = '0;
  logic [31:0] exp_rdata = '0;
  bit          m_forced = 0;
  logic [31:0] m_q[$];

  function automatic logic [7:0] m_status(int s);
    if (s == 1) return 8'hAC;
    if (s == 5) return 8'h57;
    if (s == 6) return 8'hFA;
    if (s == 8) return 8'hED;
    return 8'h00;
  endfunction

  function automatic int longest_run();
    int best = 0, cur = 0;
    foreach (m_q[i]) begin
      if (i > 0 && m_q[i] == m_q[i-1]) cur++;
      else cur = 1;
      if (cur > best) best = cur;
    end
    return best;
  endfunction

  always @(posedge clk) begin
    bit acc;
    if (!rst_n) begin
      m_state = 0; m_word = '0; exp_rdata = '0; m_forced = 0; m_q.delete();
    end else begin
      if (!bus_re) exp_rdata = '0;
      else if (bus_addr == 4'h4) exp_rdata = {24'h0, m_status(m_state)};
      else if (bus_addr == 4'h0 && m_state == 8) exp_rdata = m_word;
      else exp_rdata = '0;
      acc = 0;
      if (bus_we && bus_addr == 4'h0) begin
        if (bus_wdata == 32'h1) begin
          acc = 1; m_state = 1; m_word = '0; m_q.delete(); m_forced = 0;
        end else if (m_state == 1 && bus_wdata == 32'h2) begin acc = 1; m_state = 2; end
        else if (m_state == 2 && bus_wdata == 32'h8000_0000) begin acc = 1; m_state = 3; end
        else if (m_state == 3 && bus_wdata == 32'h8000_0004) begin
          acc = 1; m_state = 4; m_word = '0; m_q.delete(); m_forced = 0;
        end
        else if (m_state == 5 && bus_wdata == 32'h8000_0008) begin acc = 1; m_state = 7; end
        else if (m_state == 8 && bus_wdata == 32'h8000_000F) begin acc = 1; m_state = 9; end
        else if (m_state == 9 && bus_wdata == 32'h8000_0000) begin acc = 1; m_state = 7; end
      end
      if (!acc) begin
        if (m_state == 4) begin
          if (test_force_fail) m_forced = 1;
          if (src_valid) begin
            m_q.push_back(src_data);
            if (m_q.size() == NSAMP) m_state = (m_forced || longest_run() > REPL) ? 6 : 5;
          end
        end else if (m_state == 7 && src_valid) begin
          m_word = src_data; m_state = 8;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // every-clock comparison against the model (R1 bus timing)
  always @(negedge clk) begin
    if (rst_n) check(bus_rdata == exp_rdata, "R1 per-cycle", bus_rdata, exp_rdata);
  end

  function automatic logic [31:0] xs32(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
    return y;
  endfunction

  always @(negedge clk) begin
    if (src_mode == 1) begin lfsr = xs32(lfsr); src_valid <= 1'b1; src_data <= lfsr; end
    else if (src_mode == 2) begin src_valid <= 1'b1; src_data <= 32'h5A5A_5A5A; end
    else src_valid <= 1'b0;
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0; bus_addr = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_re = 1'b1; bus_addr = a;
    @(negedge clk); bus_re = 1'b0; bus_addr = '0;
    check(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bring_up(input int mode);
    wr(4'h0, 32'h1);
    rd(4'h4, 32'hAC, "R2 reset ack");
    wr(4'h0, 32'h2);
    rd(4'h4, 32'h00, "R3 released");
    wr(4'h0, 32'h8000_0000);
    rd(4'h4, 32'h00, "R3 enabled");
    src_mode = 0;
    wr(4'h0, 32'h8000_0004);
    idle(4);
    rd(4'h4, 32'h00, "R4 test waits for samples");
    src_mode = mode;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] w;
    idle(3); rst_n = 1'b1; idle(2);
    rd(4'h4, 32'h00, "R3 power-on status");
    rd(4'h0, 32'h00, "R9 data when empty");
    wr(4'h0, 32'h8000_0000);
    rd(4'h4, 32'h00, "R10 out-of-order enable");
    wr(4'h0, 32'h1234_5678);
    rd(4'h4, 32'h00, "R10 unknown command");
    wr(4'h8, 32'h1);
    rd(4'h4, 32'h00, "R10 write to other offset");
    rd(4'hC, 32'h00, "R1 other offset reads zero");

    // passing bring-up
    bring_up(1);
    idle(NSAMP + 4);
    rd(4'h4, 32'h57, "R4 pass");
    rd(4'h0, 32'h00, "R9 no word before service");
    idle(8);
    rd(4'h4, 32'h57, "R6 waits for ack-zeroize");
    wr(4'h0, 32'h8000_0008);
    idle(3);
    for (int k = 0; k < 4; k++) begin
      rd(4'h4, 32'hED, "R7 fresh word status");
      w = m_word;
      check(w != 32'h0, "R7 model captured word", w, 32'h1);
      rd(4'h0, w, "R7 data returns held word");
      idle(5);
      rd(4'h0, w, "R7 held word not replaced");
      wr(4'h0, 32'h8000_000F);
      rd(4'h4, 32'h00, "R8 status clears on read-ack");
      idle(6);
      rd(4'h4, 32'h00, "R8 no new word before enable");
      rd(4'h0, 32'h00, "R9 stale data reads zero");
      wr(4'h0, 32'h8000_0000);
      idle(2);
    end
    rd(4'h4, 32'hED, "R8 enable re-arms");
    wr(4'h4, 32'h1);
    rd(4'h4, 32'hED, "R10 command at status offset ignored");
    wr(4'h0, 32'h8000_0008);
    rd(4'h4, 32'hED, "R10 out-of-order ack-zeroize");
    wr(4'h0, 32'h1);
    rd(4'h4, 32'hAC, "R2 reset from service");
    rd(4'h0, 32'h00, "R9 reset clears word");

    // constant source: run failure
    bring_up(2);
    idle(NSAMP + 4);
    rd(4'h4, 32'hFA, "R5 repetition fail");
    wr(4'h0, 32'h8000_0008);
    rd(4'h4, 32'hFA, "R10 ack-zeroize after fail ignored");

    // forced failure with a good source
    bring_up(1);
    idle(10);
    @(negedge clk); test_force_fail = 1'b1;
    @(negedge clk); test_force_fail = 1'b0;
    idle(NSAMP);
    rd(4'h4, 32'hFA, "R5 forced fail");

    // reset mid-test
    bring_up(1);
    idle(10);
    wr(4'h0, 32'h1);
    rd(4'h4, 32'hAC, "R2 reset during test");
    src_mode = 0;
    idle(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule